// File: doc/BRIEF.md
# SPI Channel Register Bank with FIFOs and Interrupts

This block is the register side of a four-channel SPI controller. Each channel has its own bank of registers: configuration, clock divider, command, status, interrupt enable, FIFO threshold, FIFO word count, and two data ports. Each channel also holds an 8-word transmit FIFO and an 8-word receive FIFO. A shift engine, which sits outside this block, takes transmit words through a pop strobe and returns received words through a push strobe. It reports a finished transfer with a one-cycle pulse and reports its busy state as a level.

Software reaches each channel's bank at a fixed 0x40 stride. A shared system-control word sits above the last bank. That word can hold any channel in reset and carries a power-management enable. The status bits record transfer, threshold and error events, and software clears them by writing 1s. Each channel has one level interrupt: the OR of every status event whose enable bit is set. Read data is registered and appears in the cycle after the read strobe. A read of the receive data port removes the word it returns.

Top module: `spi_chan_regbank`

## Requirements
- R1: After reset every register of every channel reads 0, except status. Status reads 0x04 because an empty transmit FIFO meets a threshold of 0. The word count reads 0, every `irq` bit is 0 and `pm_en` is 0.
- R2: Channel n decodes at byte address n*0x40 plus offset. The offsets are: config 0x00 (32 bits), divider 0x04 (16 bits), command 0x08 (32 bits), interrupt enable 0x10 (5 bits) and threshold 0x14 (8 bits). Each of these reads back the written value truncated to its width, and a write reaches only the addressed channel.
- R3: A write to offset 0x1C pushes a word onto the transmit FIFO. While the FIFO is not empty, the shift engine sees the oldest word on `tx_head` and `tx_nempty` is 1. A `tx_pop` pulse removes that word. Words leave in write order. The word count register (offset 0x18) shows the transmit count in bits [7:4]. A write while 8 words are held is dropped.
- R4: A `rx_push` pulse stores `rx_word` in the receive FIFO. Reads of offset 0x20 return the stored words oldest first, and the word count shows the receive count in bits [3:0]. A read of an empty receive FIFO returns 0 and changes nothing.
- R5: The status register is at offset 0x0C. Bit 0 mirrors `busy` and cannot be written. A `ev_done` pulse sets bit 1. A `tx_pop` with an empty transmit FIFO sets bit 4. A `rx_push` with a full receive FIFO drops the word and sets bit 5.
- R6: Writing 1 to status bits [5:1] clears them, and writing 0 leaves them unchanged. If a condition still holds in the cycle of the clearing write, its bit stays set.
- R7: The threshold register holds the transmit level in bits [3:0] and the receive level in bits [7:4]. Status bit 2 is set in any cycle where the transmit count is at or below its level. Status bit 3 is set in any cycle where the receive count is nonzero and at or above its level.
- R8: For each k from 0 to 4, `irq` is high when enable bit k is set together with status bit k+1. Status bit 0 never raises `irq`.
- R9: The system-control word is at byte address 0x100. Bit n of this word holds channel n in reset. While held, that channel's FIFOs are empty, its status events and registers read 0, bus writes to it are ignored, and `chan_hold` shows the held channels. Bit 8 drives `pm_en`. Other channels are unaffected by the hold.
- R10: A write to the command register updates `cmd_o` and raises `cmd_go` for that channel for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | AW | Byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after `rd_en` |
| busy | input | NUM_CH | Per-channel transfer in progress |
| ev_done | input | NUM_CH | Per-channel transfer-finished pulse |
| tx_pop | input | NUM_CH | Shift engine takes the transmit head |
| tx_head | output | NUM_CH*DW | Oldest transmit word per channel (0 when empty) |
| tx_nempty | output | NUM_CH | Transmit FIFO holds at least one word |
| rx_push | input | NUM_CH | Shift engine stores a received word |
| rx_word | input | NUM_CH*DW | Received word per channel |
| cfg_o | output | NUM_CH*DW | Config register per channel |
| div_o | output | NUM_CH*16 | Divider register per channel |
| cmd_o | output | NUM_CH*DW | Command register per channel |
| cmd_go | output | NUM_CH | One-cycle pulse after a command write |
| chan_hold | output | NUM_CH | Channel held in reset |
| pm_en | output | 1 | Power-management enable |
| irq | output | NUM_CH | Level interrupt per channel |

## Verification
The bench uses the default parameters: four channels, eight-word FIFOs and a 9-bit address. With a depth of 8, a channel can be filled to the brim, pushed once more to force an overflow, and drained past empty to force an underflow, all within a few dozen cycles. Four channels let one channel be held in reset while its neighbours keep their contents. The system-control word then decodes just past the last bank at 0x100.

// File: rtl/spi_chan_regbank.sv
module spi_chan_regbank #(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8,
  parameter int DW     = 32,
  parameter int AW     = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [NUM_CH-1:0]    busy,
  input  logic [NUM_CH-1:0]    ev_done,
  input  logic [NUM_CH-1:0]    tx_pop,
  output logic [NUM_CH*DW-1:0] tx_head,
  output logic [NUM_CH-1:0]    tx_nempty,
  input  logic [NUM_CH-1:0]    rx_push,
  input  logic [NUM_CH*DW-1:0] rx_word,
  output logic [NUM_CH*DW-1:0] cfg_o,
  output logic [NUM_CH*16-1:0] div_o,
  output logic [NUM_CH*DW-1:0] cmd_o,
  output logic [NUM_CH-1:0]    cmd_go,
  output logic [NUM_CH-1:0]    chan_hold,
  output logic                 pm_en,
  output logic [NUM_CH-1:0]    irq
);

  localparam int PW       = $clog2(DEPTH);
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int CHW      = $clog2(NUM_CH);
  localparam int STRIDE   = 64;
  localparam int BANK_END = NUM_CH * STRIDE;
  localparam int SYS_ADDR = 256;

  localparam logic [5:0] O_CFG = 6'h00;
  localparam logic [5:0] O_DIV = 6'h04;
  localparam logic [5:0] O_CMD = 6'h08;
  localparam logic [5:0] O_ST  = 6'h0C;
  localparam logic [5:0] O_IE  = 6'h10;
  localparam logic [5:0] O_THR = 6'h14;
  localparam logic [5:0] O_CNT = 6'h18;
  localparam logic [5:0] O_TXD = 6'h1C;
  localparam logic [5:0] O_RXD = 6'h20;

  logic           in_bank, sys_hit;
  logic [CHW-1:0] ch;
  logic [5:0]     off;

  assign in_bank = addr < AW'(BANK_END);
  assign sys_hit = addr == AW'(SYS_ADDR);
  assign ch      = addr[6 +: CHW];
  assign off     = addr[5:0];

  logic [NUM_CH-1:0] hold_q;
  logic              pm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pm_q   <= 1'b0;
    end else if (wr_en && sys_hit) begin
      hold_q <= wdata[NUM_CH-1:0];
      pm_q   <= wdata[8];
    end
  end

  assign chan_hold = hold_q;
  assign pm_en     = pm_q;

  logic [NUM_CH-1:0][DW-1:0] cfg_a, cmd_a, rxh_a;
  logic [NUM_CH-1:0][15:0]   div_a;
  logic [NUM_CH-1:0][5:0]    st_a;
  logic [NUM_CH-1:0][4:0]    ie_a;
  logic [NUM_CH-1:0][7:0]    thr_a;
  logic [NUM_CH-1:0][3:0]    txc_a, rxc_a;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic          crst, hit, wr;
    logic [DW-1:0] cfg_r, cmd_r;
    logic [15:0]   div_r;
    logic [4:0]    ie_r;
    logic [7:0]    thr_r;
    logic          go_r;
    logic [5:1]    ev_r;
    logic [DW-1:0] txm [DEPTH];
    logic [DW-1:0] rxm [DEPTH];
    logic [PW-1:0] txw, txr, rxw, rxr;
    logic [CW-1:0] txc, rxc;
    logic          tx_put, tx_take, rx_put, rx_take, tx_th, rx_th;

    assign crst    = hold_q[c];
    assign hit     = in_bank && (ch == CHW'(c));
    assign wr      = wr_en && hit && !crst;
    assign tx_put  = wr && off == O_TXD && txc != CW'(DEPTH);
    assign tx_take = tx_pop[c] && txc != '0;
    assign rx_put  = rx_push[c] && rxc != CW'(DEPTH);
    assign rx_take = rd_en && hit && !crst && off == O_RXD && rxc != '0;
    assign tx_th   = 8'(txc) <= 8'(thr_r[3:0]);
    assign rx_th   = rxc != '0 && 8'(rxc) >= 8'(thr_r[7:4]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_r <= '0; div_r <= '0; cmd_r <= '0;
        ie_r  <= '0; thr_r <= '0; go_r  <= 1'b0;
      end else if (crst) begin
        cfg_r <= '0; div_r <= '0; cmd_r <= '0;
        ie_r  <= '0; thr_r <= '0; go_r  <= 1'b0;
      end else begin
        go_r <= wr && off == O_CMD;
        if (wr) begin
          case (off)
            O_CFG:   cfg_r <= wdata;
            O_DIV:   div_r <= wdata[15:0];
            O_CMD:   cmd_r <= wdata;
            O_IE:    ie_r  <= wdata[4:0];
            O_THR:   thr_r <= wdata[7:0];
            default: ;
          endcase
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_r <= '0;
      end else if (crst) begin
        ev_r <= '0;
      end else begin
        ev_r <= ev_r & ~((wr && off == O_ST) ? wdata[5:1] : 5'b0);
        if (ev_done[c])                       ev_r[1] <= 1'b1;
        if (tx_th)                            ev_r[2] <= 1'b1;
        if (rx_th)                            ev_r[3] <= 1'b1;
        if (tx_pop[c] && txc == '0)           ev_r[4] <= 1'b1;
        if (rx_push[c] && rxc == CW'(DEPTH))  ev_r[5] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        txw <= '0; txr <= '0; txc <= '0;
        rxw <= '0; rxr <= '0; rxc <= '0;
      end else if (crst) begin
        txw <= '0; txr <= '0; txc <= '0;
        rxw <= '0; rxr <= '0; rxc <= '0;
      end else begin
        if (tx_put)  txw <= txw + 1'b1;
        if (tx_take) txr <= txr + 1'b1;
        if (rx_put)  rxw <= rxw + 1'b1;
        if (rx_take) rxr <= rxr + 1'b1;
        txc <= txc + CW'(tx_put) - CW'(tx_take);
        rxc <= rxc + CW'(rx_put) - CW'(rx_take);
      end
    end

    always_ff @(posedge clk) begin
      if (tx_put) txm[txw] <= wdata;
      if (rx_put && !crst) rxm[rxw] <= rx_word[c*DW +: DW];
    end

    assign tx_head[c*DW +: DW] = (txc != '0) ? txm[txr] : '0;
    assign tx_nempty[c]        = txc != '0;
    assign cfg_o[c*DW +: DW]   = cfg_r;
    assign div_o[c*16 +: 16]   = div_r;
    assign cmd_o[c*DW +: DW]   = cmd_r;
    assign cmd_go[c]           = go_r;
    assign irq[c]              = |(ie_r & ev_r);

    assign cfg_a[c] = cfg_r;
    assign cmd_a[c] = cmd_r;
    assign div_a[c] = div_r;
    assign ie_a[c]  = ie_r;
    assign thr_a[c] = thr_r;
    assign st_a[c]  = {ev_r, busy[c]};
    assign txc_a[c] = 4'(txc);
    assign rxc_a[c] = 4'(rxc);
    assign rxh_a[c] = (rxc != '0) ? rxm[rxr] : '0;

    p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      txc <= CW'(DEPTH));
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && off == O_TXD && txc == CW'(DEPTH) && !tx_pop[c]) |=> txc == CW'(DEPTH));
    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hit && off == O_RXD && rxc == '0 && !rx_push[c]) |=> rxc == '0);
    p_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop[c] && txc == '0 && !crst) |=> ev_r[4]);
    p_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push[c] && rxc == CW'(DEPTH) && !crst) |=> ev_r[5]);
    p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done[c] && ie_r[0] && !crst && !(wr && off == O_IE)) |=> irq[c]);
    p_hold_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      crst |=> (txc == '0 && rxc == '0 && ev_r == '0 && cfg_r == '0));
    p_cmd_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && off == O_CMD) |=> (go_r && cmd_r == $past(wdata)));
  end

  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (sys_hit) begin
      rd_mux[NUM_CH-1:0] = hold_q;
      rd_mux[8]          = pm_q;
    end else if (in_bank) begin
      case (off)
        O_CFG:   rd_mux = cfg_a[ch];
        O_DIV:   rd_mux = DW'(div_a[ch]);
        O_CMD:   rd_mux = cmd_a[ch];
        O_ST:    rd_mux = DW'(st_a[ch]);
        O_IE:    rd_mux = DW'(ie_a[ch]);
        O_THR:   rd_mux = DW'(thr_a[ch]);
        O_CNT:   rd_mux = DW'({txc_a[ch], rxc_a[ch]});
        O_RXD:   rd_mux = rxh_a[ch];
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: tb/sim_spi_chan_regbank.sv
module sim_spi_chan_regbank;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [NCH-1:0] busy = '0, ev_done = '0, tx_pop = '0, rx_push = '0;
  logic [NCH*32-1:0] tx_head, rx_word = '0, cfg_o, cmd_o;
  logic [NCH*16-1:0] div_o;
  logic [NCH-1:0] tx_nempty, cmd_go, chan_hold, irq;
  logic           pm_en;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  spi_chan_regbank u0 (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .busy, .ev_done, .tx_pop, .tx_head, .tx_nempty, .rx_push, .rx_word,
    .cfg_o, .div_o, .cmd_o, .cmd_go, .chan_hold, .pm_en, .irq
  );

  function automatic logic [8:0] ra(int c, int o);
    return 9'(c * 64 + o);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pop_tx(int c);
    @(negedge clk); tx_pop[c] = 1'b1;
    @(negedge clk); tx_pop[c] = 1'b0;
  endtask

  task automatic push_rx(int c, logic [31:0] d);
    @(negedge clk); rx_push[c] = 1'b1; rx_word[c*32 +: 32] = d;
    @(negedge clk); rx_push[c] = 1'b0;
  endtask

  task automatic t_reset;
    bus_rd(ra(0, 'h00), rv); chk("R1 cfg reset", rv, 0);
    bus_rd(ra(2, 'h04), rv); chk("R1 div reset", rv, 0);
    bus_rd(ra(1, 'h0C), rv); chk("R1 status reset", rv, 32'h04);
    bus_rd(ra(0, 'h18), rv); chk("R1 count reset", rv, 0);
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 pm_en reset", 32'(pm_en), 0);
  endtask

  task automatic t_regs;
    bus_wr(ra(3, 'h00), 32'hC0FFEE01);
    bus_wr(ra(3, 'h04), 32'hABCD1234);
    bus_wr(ra(3, 'h10), 32'hFFFFFFFF);
    bus_wr(ra(3, 'h14), 32'h00001234);
    bus_rd(ra(3, 'h00), rv); chk("R2 cfg readback", rv, 32'hC0FFEE01);
    bus_rd(ra(3, 'h04), rv); chk("R2 div 16-bit", rv, 32'h1234);
    bus_rd(ra(3, 'h10), rv); chk("R2 ie 5-bit", rv, 32'h1F);
    bus_rd(ra(3, 'h14), rv); chk("R2 thr 8-bit", rv, 32'h34);
    bus_rd(ra(2, 'h00), rv); chk("R2 other channel cfg", rv, 0);
    chk("R2 cfg_o slice", cfg_o[3*32 +: 32], 32'hC0FFEE01);
  endtask

  task automatic t_cmd;
    bus_wr(ra(2, 'h08), 32'h001F0013);
    chk("R10 cmd_go pulse", 32'(cmd_go), 32'b0100);
    chk("R10 cmd_o value", cmd_o[2*32 +: 32], 32'h001F0013);
    idle(1);
    chk("R10 cmd_go one cycle", 32'(cmd_go), 0);
  endtask

  task automatic t_txfifo;
    for (int i = 0; i < 9; i++) bus_wr(ra(0, 'h1C), 32'hA000_0000 + 32'(i));
    bus_rd(ra(0, 'h18), rv); chk("R3 count full", rv, 32'h80);
    chk("R3 nempty", 32'(tx_nempty[0]), 1);
    for (int i = 0; i < 8; i++) begin
      chk("R3 head order", tx_head[31:0], 32'hA000_0000 + 32'(i));
      pop_tx(0);
    end
    chk("R3 dropped ninth word", 32'(tx_nempty[0]), 0);
    bus_rd(ra(0, 'h18), rv); chk("R3 count drained", rv, 0);
  endtask

  task automatic t_status;
    pop_tx(0);
    bus_rd(ra(0, 'h0C), rv); chk("R5 underflow bit4", rv, 32'h14);
    bus_wr(ra(0, 'h0C), 32'h10);
    bus_rd(ra(0, 'h0C), rv); chk("R6 w1c clears bit4", rv, 32'h04);
    bus_wr(ra(0, 'h0C), 32'h04);
    bus_rd(ra(0, 'h0C), rv); chk("R6 held condition stays", rv, 32'h04);
    busy[0] = 1'b1;
    bus_wr(ra(0, 'h0C), 32'h01);
    bus_rd(ra(0, 'h0C), rv); chk("R5 pending mirrors busy", rv, 32'h05);
    busy[0] = 1'b0;
  endtask

  task automatic t_rxfifo;
    for (int i = 0; i < 9; i++) push_rx(1, 32'h5000_0000 + 32'(i));
    idle(2);
    bus_rd(ra(1, 'h0C), rv); chk("R5 overflow bit5", rv, 32'h2C);
    bus_rd(ra(1, 'h18), rv); chk("R4 rx count full", rv, 32'h08);
    for (int i = 0; i < 8; i++) begin
      bus_rd(ra(1, 'h20), rv); chk("R4 rx order", rv, 32'h5000_0000 + 32'(i));
    end
    bus_rd(ra(1, 'h20), rv); chk("R4 empty read zero", rv, 0);
    bus_rd(ra(1, 'h18), rv); chk("R4 rx count empty", rv, 0);
    bus_wr(ra(1, 'h0C), 32'h3E);
    bus_rd(ra(1, 'h0C), rv); chk("R6 w1c all events", rv, 32'h04);
  endtask

  task automatic t_thresh;
    bus_wr(ra(2, 'h14), 32'h32);
    for (int i = 0; i < 3; i++) bus_wr(ra(2, 'h1C), 32'(i));
    idle(2);
    bus_wr(ra(2, 'h0C), 32'h3E);
    bus_rd(ra(2, 'h0C), rv); chk("R7 tx above level", rv, 0);
    push_rx(2, 32'h11); push_rx(2, 32'h22);
    idle(2);
    bus_wr(ra(2, 'h0C), 32'h3E);
    bus_rd(ra(2, 'h0C), rv); chk("R7 rx below level", rv, 0);
    push_rx(2, 32'h33);
    idle(2);
    bus_rd(ra(2, 'h0C), rv); chk("R7 rx reaches level", rv, 32'h08);
    pop_tx(2);
    idle(2);
    bus_rd(ra(2, 'h0C), rv); chk("R7 tx reaches level", rv, 32'h0C);
    bus_rd(ra(2, 'h18), rv); chk("R7 count fields", rv, 32'h23);
  endtask

  task automatic t_irq;
    bus_wr(ra(0, 'h10), 32'h01);
    busy[0] = 1'b1;
    idle(1);
    chk("R8 pending gives no irq", 32'(irq[0]), 0);
    @(negedge clk); ev_done[0] = 1'b1;
    @(negedge clk); ev_done[0] = 1'b0;
    chk("R8 done raises irq", 32'(irq[0]), 1);
    bus_rd(ra(0, 'h0C), rv); chk("R5 done bit1", rv, 32'h07);
    bus_wr(ra(0, 'h0C), 32'h02);
    chk("R8 cleared done drops irq", 32'(irq[0]), 0);
    bus_wr(ra(0, 'h10), 32'h02);
    chk("R8 threshold enable irq", 32'(irq[0]), 1);
    bus_wr(ra(0, 'h10), 32'h00);
    chk("R8 all disabled", 32'(irq[0]), 0);
    busy[0] = 1'b0;
  endtask

  task automatic t_hold;
    push_rx(3, 32'hDEAD0003);
    bus_wr(ra(3, 'h1C), 32'hBEEF0003);
    bus_wr(ra(0, 'h00), 32'h5A);
    bus_wr(9'h100, 32'h108);
    chk("R9 chan_hold", 32'(chan_hold), 32'b1000);
    chk("R9 pm_en", 32'(pm_en), 1);
    bus_rd(ra(3, 'h00), rv); chk("R9 cfg cleared", rv, 0);
    bus_rd(ra(3, 'h14), rv); chk("R9 thr cleared", rv, 0);
    bus_rd(ra(3, 'h18), rv); chk("R9 fifos emptied", rv, 0);
    bus_rd(ra(3, 'h0C), rv); chk("R9 status cleared", rv, 0);
    bus_wr(ra(3, 'h00), 32'h77);
    bus_rd(ra(3, 'h00), rv); chk("R9 write ignored", rv, 0);
    bus_rd(ra(0, 'h00), rv); chk("R9 neighbour kept", rv, 32'h5A);
    chk("R9 tx head empty", tx_head[3*32 +: 32], 0);
    bus_wr(9'h100, 32'h100);
    bus_rd(9'h100, rv); chk("R9 sys readback", rv, 32'h100);
    chk("R9 released", 32'(chan_hold), 0);
    bus_rd(ra(3, 'h00), rv); chk("R9 cfg stays reset", rv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regs();
    t_cmd();
    t_txfifo();
    t_status();
    t_rxfifo();
    t_thresh();
    t_irq();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule